// File: doc/BRIEF.md
# Half-Select Exact Leading-One Detector

This block finds the most significant set bit of a 32-bit operand without any approximation. It does so with a search stage only half as wide as the operand. An OR-reduction of the upper 16 bits decides which half is routed to a 16-bit priority detector. If the upper half contains any set bit, that half is routed. Otherwise the lower half is routed.

The routing decision becomes the top bit of the reported position. The inner detector supplies the remaining four bits. The inner one-hot result is then placed back into the correct half of a 32-bit one-hot vector.

The block is purely combinational and sits in front of logarithm, normalisation or priority logic. A zero flag marks the all-zero operand. For that operand both the position and the one-hot vector are driven to zero.

Top module: `lod_halfsel_top`

## Requirements
- R1: For a nonzero operand, `onehot_o` has exactly one bit set, at the index of the operand's most significant set bit.
- R2: For a nonzero operand, `pos_o` is the unsigned binary index (0 = least significant bit, 31 = most significant) of the most significant set bit.
- R3: `pos_o[4]` is 1 exactly when at least one bit of `operand_i[31:16]` is set.
- R4: When `operand_i[31:16]` is nonzero, the bits of `operand_i[15:0]` have no effect on any output, and `onehot_o[15:0]` is zero.
- R5: When `operand_i[31:16]` is zero, `onehot_o[31:16]` is zero and the result is taken from the lower half alone.
- R6: For an all-zero operand, `zero_o` is 1, `pos_o` is 0 and `onehot_o` is all zeros.
- R7: For any nonzero operand, `zero_o` is 0.
- R8: For a nonzero operand, the bit of `onehot_o` indexed by `pos_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be searched |
| pos_o | output | 5 | Index of the most significant set bit |
| onehot_o | output | 32 | One-hot marker of the most significant set bit |
| zero_o | output | 1 | High when the operand has no set bit |

## Verification
The checker takes for granted that `operand_i` carries only known 0/1 values. It skips evaluation while any bit is unknown, because an undefined operand has no defined leading one. The bench drives every operand from a task with fully defined values. These cover every single-bit operand, the all-zero and all-ones operands, operands at the half boundary, and random operands restricted either to an empty upper half or to a populated one. It compares the outputs only half a clock after each change, so the combinational outputs have settled before they are checked.

// File: rtl/lod_pkg.sv
package lod_pkg;
  localparam int unsigned OPERAND_W = 32;
  localparam int unsigned HALF_W    = OPERAND_W / 2;
  localparam int unsigned POS_W     = $clog2(OPERAND_W);
  localparam int unsigned HPOS_W    = $clog2(HALF_W);
endpackage

// File: rtl/lod_half_select.sv
// Tests the upper half for any set bit and routes one half onward.
module lod_half_select #(
  parameter  int unsigned W = lod_pkg::OPERAND_W,
  localparam int unsigned H = W / 2
) (
  input  logic [W-1:0] operand_i,
  output logic         upper_nz_o,
  output logic [H-1:0] half_o
);

  assign upper_nz_o = |operand_i[W-1:H];
  assign half_o     = upper_nz_o ? operand_i[W-1:H] : operand_i[H-1:0];

endmodule

// File: rtl/lod_prio_core.sv
// Exact priority detector: one-hot of the highest set bit plus its binary index.
module lod_prio_core #(
  parameter  int unsigned W  = lod_pkg::HALF_W,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [W-1:0]  onehot_o,
  output logic [PW-1:0] pos_o,
  output logic          any_o
);

  always_comb begin
    logic higher;
    higher   = 1'b0;
    onehot_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      onehot_o[i] = vec_i[i] & ~higher;
      higher      = higher | vec_i[i];
    end
  end

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot_o[i]) pos_o = pos_o | PW'(i);
    end
  end

  assign any_o = |vec_i;

endmodule

// File: rtl/lod_onehot_place.sv
// Puts the half-width one-hot into the half chosen by the select flag.
module lod_onehot_place #(
  parameter  int unsigned H = lod_pkg::HALF_W,
  localparam int unsigned W = 2 * H
) (
  input  logic [H-1:0] inner_i,
  input  logic         upper_i,
  output logic [W-1:0] full_o
);

  assign full_o = upper_i ? {inner_i, {H{1'b0}}} : {{H{1'b0}}, inner_i};

endmodule

// File: rtl/lod_halfsel_top.sv
module lod_halfsel_top #(
  parameter  int unsigned OPERAND_W = lod_pkg::OPERAND_W,
  localparam int unsigned HALF_W    = OPERAND_W / 2,
  localparam int unsigned POS_W     = $clog2(OPERAND_W),
  localparam int unsigned HPOS_W    = $clog2(HALF_W)
) (
  input  logic [OPERAND_W-1:0] operand_i,
  output logic [POS_W-1:0]     pos_o,
  output logic [OPERAND_W-1:0] onehot_o,
  output logic                 zero_o
);

  logic              upper_nz;
  logic [HALF_W-1:0] half_vec;
  logic [HALF_W-1:0] inner_onehot;
  logic [HPOS_W-1:0] inner_pos;
  logic              inner_any;

  lod_half_select #(.W(OPERAND_W)) sel_i (
    .operand_i  (operand_i),
    .upper_nz_o (upper_nz),
    .half_o     (half_vec)
  );

  lod_prio_core #(.W(HALF_W)) core_i (
    .vec_i    (half_vec),
    .onehot_o (inner_onehot),
    .pos_o    (inner_pos),
    .any_o    (inner_any)
  );

  lod_onehot_place #(.H(HALF_W)) place_i (
    .inner_i (inner_onehot),
    .upper_i (upper_nz),
    .full_o  (onehot_o)
  );

  // The routed half is nonzero exactly when the whole operand is nonzero.
  assign pos_o  = {upper_nz, inner_pos};
  assign zero_o = ~inner_any;

endmodule

// File: rtl/lod_halfsel_chk.sv
module lod_halfsel_chk #(
  parameter  int unsigned OPERAND_W = lod_pkg::OPERAND_W,
  localparam int unsigned HALF_W    = OPERAND_W / 2,
  localparam int unsigned POS_W     = $clog2(OPERAND_W)
) (
  input logic [OPERAND_W-1:0] operand_i,
  input logic [POS_W-1:0]     pos_o,
  input logic [OPERAND_W-1:0] onehot_o,
  input logic                 zero_o
);

  always_comb begin
    if (!$isunknown(operand_i)) begin
      // R1
      onehot_valid_chk: assert ($onehot0(onehot_o) && ((operand_i != '0) == (onehot_o != '0)))
        else $error("onehot_o is not a single marker");
      // R2
      pos_msb_chk: assert ((operand_i == '0) || ((operand_i >> pos_o) == OPERAND_W'(1)))
        else $error("pos_o does not mark the highest set bit");
      // R3
      upper_sel_chk: assert (pos_o[POS_W-1] == (operand_i[OPERAND_W-1:HALF_W] != '0))
        else $error("pos_o top bit disagrees with upper half");
      // R4
      lower_quiet_chk: assert ((operand_i[OPERAND_W-1:HALF_W] == '0) || (onehot_o[HALF_W-1:0] == '0))
        else $error("lower one-hot bits set while upper half populated");
      // R5
      upper_quiet_chk: assert ((operand_i[OPERAND_W-1:HALF_W] != '0) || (onehot_o[OPERAND_W-1:HALF_W] == '0))
        else $error("upper one-hot bits set while upper half empty");
      // R6
      zero_outputs_chk: assert ((operand_i != '0) || (zero_o && pos_o == '0 && onehot_o == '0))
        else $error("zero operand outputs wrong");
      // R7
      nonzero_flag_chk: assert ((operand_i == '0) || !zero_o)
        else $error("zero flag set for nonzero operand");
      // R8
      pos_onehot_chk: assert (zero_o || onehot_o[pos_o])
        else $error("onehot_o and pos_o disagree");
    end
  end

endmodule

bind lod_halfsel_top lod_halfsel_chk #(.OPERAND_W(OPERAND_W)) chk_i (
  .operand_i (operand_i),
  .pos_o     (pos_o),
  .onehot_o  (onehot_o),
  .zero_o    (zero_o)
);

// File: tb/lod_halfsel_top_tb_top.sv
module lod_halfsel_top_tb_top;

  typedef struct {
    logic [31:0] operand;
    logic [4:0]  pos;
    logic [31:0] onehot;
    logic        zero;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  pos;
  logic [31:0] onehot;
  logic        zero;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  lod_halfsel_top dut_i (
    .operand_i (operand),
    .pos_o     (pos),
    .onehot_o  (onehot),
    .zero_o    (zero)
  );

  function automatic exp_t model(input logic [31:0] v, input string tag);
    exp_t e;
    e.operand = v;
    e.pos     = '0;
    e.onehot  = '0;
    e.zero    = (v == '0);
    e.tag     = tag;
    for (int i = 31; i >= 0; i--) begin
      if (v[i] && e.onehot == '0) begin
        e.onehot = 32'(1) << i;
        e.pos    = 5'(i);
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] v, input string tag);
    @(posedge clk);
    operand = v;
    sb_q.push_back(model(v, tag));
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp, input logic [31:0] opnd);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s operand=%h actual=%h expected=%h", req, what, opnd, act, exp);
    end
  endtask

  // Monitor: compare settled outputs half a cycle after each drive.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(onehot == e.onehot, "R1", {e.tag, " onehot"}, onehot, e.onehot, e.operand);
      check(pos == e.pos, "R2", {e.tag, " pos"}, 32'(pos), 32'(e.pos), e.operand);
      check(pos[4] == (e.operand[31:16] != '0), "R3", {e.tag, " select bit"},
            32'(pos[4]), 32'(e.operand[31:16] != '0), e.operand);
      check(zero == e.zero, e.zero ? "R6" : "R7", {e.tag, " zero flag"},
            32'(zero), 32'(e.zero), e.operand);
      if (!e.zero)
        check(onehot[pos] == 1'b1, "R8", {e.tag, " onehot at pos"},
              32'(onehot[pos]), 32'd1, e.operand);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    // R6: all-zero operand
    drive(32'h0, "R6 zero");
    // R1 R2: every single-bit operand
    for (int i = 0; i < 32; i++) drive(32'(1) << i, "R1 single");
    // R2: all ones, boundary around the half split
    drive(32'hFFFF_FFFF, "R2 ones");
    drive(32'h0001_0000, "R3 boundary up");
    drive(32'h0000_FFFF, "R5 boundary low");
    drive(32'h0000_8000, "R5 lower top");
    // R4: fixed upper half, varying lower half gives identical results
    for (int i = 0; i < 200; i++) begin
      r = $urandom;
      drive({16'h0040, r[15:0]}, "R4 lower ignored");
    end
    // R4: random populated upper half
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      if (r[31:16] == '0) r[16] = 1'b1;
      drive(r, "R4 upper populated");
    end
    // R5: random empty upper half
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      drive({16'h0, r[15:0]}, "R5 upper empty");
    end
    // Fully random operands
    for (int i = 0; i < 800; i++) drive($urandom, "R2 random");
    drive(32'h0, "R6 zero again");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule